// File: doc/BRIEF.md
# Stereo Soft Mute with Linear Gain Ramp

This block fades a stereo stream of 24-bit two's-complement samples in and out without an audible click. A single gain value, shared by both channels, walks between unity and zero in steps of one per frame strobe. Every strobed sample pair is multiplied by that gain and sent out. Holding the mute request high drives the gain down to zero. Releasing the request drives it back up. A change of the request part way through a ramp turns the ramp around from wherever the gain stands. It does not restart the ramp.

The ramp length is a count of frames, not a span of time. With the default parameter, a full fade takes 1024 strobes. While the gain sits at zero, the outputs are exactly zero and a status flag reports the fully muted state. The block sits in the sample path after the serial receiver, and it expects one strobe per stereo frame.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is asserted, and until the first strobe after reset, both outputs are zero and `muted` is low. After reset the gain is unity, so the first strobed pair passes through unchanged.
- R2: On each cycle with `frame_vld` high, the block registers an output equal to sample × g / 1024, truncated toward zero. Here g is the gain in effect before that strobe's ramp step. The output appears one clock after the strobe and holds until the next strobe. At g = 1024 every sample, including -8388608, passes through unchanged.
- R3: On each strobe with `mute_req` high (1 = mute), the gain drops by exactly one and stops at 0.
- R4: On each strobe with `mute_req` low (0 = play), the gain rises by exactly one and stops at 1024.
- R5: Starting from unity, `muted` rises after exactly the 1024th consecutive muting strobe, and not after the 1023rd.
- R6: While the gain is zero, every strobed sample gives an output of exactly zero, for as long as mute stays requested.
- R7: When the request is released mid-ramp, the gain reverses from its present value and climbs one step per strobe, with no jump.
- R8: Both channels are always scaled by the same gain.
- R9: `muted` is high exactly when the gain is zero.
- R10: With `frame_vld` low, changes on `mute_req` and on the samples have no effect. The outputs hold, and the gain seen by the next strobe is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_vld | input | 1 | One-cycle strobe per stereo frame |
| mute_req | input | 1 | Mute request level: 1 ramps down, 0 ramps up |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| muted | output | 1 | High while the gain is zero |

## Verification
A wrong gain shows up at the outputs on the very next strobe, because every strobed sample is compared with the arithmetic product for the gain the model expects. An off-by-one in the ramp or in its saturation moves the `muted` edge by one strobe, so `muted` is checked after every strobe. A lost or extra step during a reversal shifts the gain for every later frame of the ramp. The bench therefore sweeps every gain level from unity to zero and back, with corner and varied sample values. Idle cycles that disturb the inputs are checked both on the held outputs and on the gain that the following strobe reveals.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_e;
endpackage

// File: rtl/sm_rst_sync.sv
module sm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sm_gain_ctrl.sv
module sm_gain_ctrl
  import soft_mute_pkg::*;
#(
  parameter int RAMP_LOG2 = 10,
  localparam int CNT_W = RAMP_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic             mute_req,
  output logic [CNT_W-1:0] gain,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RAMP_LOG2;

  logic [CNT_W-1:0] gain_q, gain_d;
  step_e            step;

  always_comb begin
    step = STEP_HOLD;
    if (frame_vld) begin
      if (mute_req) begin
        if (gain_q != '0) step = STEP_DOWN;
      end else begin
        if (gain_q != FULL) step = STEP_UP;
      end
    end
  end

  always_comb begin
    unique case (step)
      STEP_DOWN: gain_d = gain_q - CNT_W'(1);
      STEP_UP:   gain_d = gain_q + CNT_W'(1);
      default:   gain_d = gain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain_q <= FULL;
    else if (frame_vld) gain_q <= gain_d;
  end

  assign gain    = gain_q;
  assign at_zero = (gain_q == '0);

  assert_gain_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= FULL);
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && mute_req && gain_q != '0) |=> (gain_q == $past(gain_q) - CNT_W'(1)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(gain_q));
  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && mute_req && gain_q == '0) |=> (gain_q == '0));
endmodule

// File: rtl/sm_scaler.sv
module sm_scaler #(
  parameter int DATA_W    = 24,
  parameter int RAMP_LOG2 = 10,
  localparam int CNT_W  = RAMP_LOG2 + 1,
  localparam int MAG_W  = DATA_W + 1,
  localparam int PROD_W = DATA_W + 1 + RAMP_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  gain,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << RAMP_LOG2;

  logic              neg;
  logic [MAG_W-1:0]  mag;
  logic [PROD_W-1:0] prod, shifted, result;
  logic [DATA_W-1:0] dout_q, dout_d;

  always_comb begin
    neg     = din[DATA_W-1];
    mag     = neg ? (~{1'b1, din} + MAG_W'(1)) : {1'b0, din};
    prod    = {{RAMP_LOG2{1'b0}}, mag} * {{DATA_W{1'b0}}, gain};
    shifted = prod >> RAMP_LOG2;
    result  = neg ? (~shifted + PROD_W'(1)) : shifted;
    dout_d  = result[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout_q <= '0;
    else if (load) dout_q <= dout_d;
  end

  assign dout = dout_q;

  assert_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (result[PROD_W-1:DATA_W-1] == {(PROD_W-DATA_W+1){result[DATA_W-1]}}));
  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && gain == FULL) |=> (dout_q == $past(din)));
  assert_zero_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && gain == '0) |=> (dout_q == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout_q));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W    = 24,
  parameter int RAMP_LOG2 = 10,
  parameter int N_CH      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic              mute_req,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              muted
);
  localparam int CNT_W = RAMP_LOG2 + 1;

  logic             rst_n_s;
  logic [CNT_W-1:0] gain;
  logic             at_zero;
  logic [DATA_W-1:0] ch_in  [N_CH];
  logic [DATA_W-1:0] ch_out [N_CH];

  sm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sm_gain_ctrl #(.RAMP_LOG2(RAMP_LOG2)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_vld (frame_vld),
    .mute_req  (mute_req),
    .gain      (gain),
    .at_zero   (at_zero)
  );

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sm_scaler #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scale (
      .clk   (clk),
      .rst_n (rst_n_s),
      .load  (frame_vld),
      .gain  (gain),
      .din   (ch_in[c]),
      .dout  (ch_out[c])
    );
  end

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];
  assign muted     = at_zero;

  assert_same_gain_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_vld && left_in == right_in) |=> (left_out == right_out));
  assert_muted_out_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_vld && muted && mute_req) |=> (muted && left_out == '0 && right_out == '0));
endmodule

// File: tb/soft_mute_ramp_tb.sv
module soft_mute_ramp_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_vld;
  logic mute_req;
  logic [23:0] left_in, right_in;
  logic [23:0] left_out, right_out;
  logic muted;

  int total = 0;
  int bad = 0;
  int g_model = 1024;
  bit done = 0;

  always #10 clk = ~clk;

  soft_mute_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .mute_req(mute_req),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .muted(muted)
  );

  function automatic logic [23:0] sample(input int k);
    case (k % 9)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      3: return 24'hFFFFFF;
      4: return 24'h000001;
      default: return 24'(k * 32'h9E3779B1 + 32'h1234);
    endcase
  endfunction

  function automatic longint exp_scale(input logic [23:0] s, input int g);
    longint v, m, p;
    v = longint'($signed(s));
    m = (v < 0) ? -v : v;
    p = (m * g) >>> 10;
    return (v < 0) ? -p : p;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int k, input bit m, input string req);
    logic [23:0] l, r;
    l = sample(k);
    r = sample(k + 5);
    left_in = l; right_in = r; mute_req = m; frame_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_vld = 1'b0;
    check({req, " R2 R8 left"},  longint'($signed(left_out)),  exp_scale(l, g_model));
    check({req, " R2 R8 right"}, longint'($signed(right_out)), exp_scale(r, g_model));
    if (m) g_model = (g_model > 0) ? g_model - 1 : 0;
    else   g_model = (g_model < 1024) ? g_model + 1 : 1024;
    check({req, " R9 muted"}, longint'(muted), longint'(g_model == 0));
  endtask

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_vld = 1'b0; mute_req = 1'b0;
    left_in = 24'h123456; right_in = 24'h654321;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 left reset",  longint'(left_out),  0);
    check("R1 right reset", longint'(right_out), 0);
    check("R1 muted reset", longint'(muted),     0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 left after release", longint'(left_out), 0);
    // R1/R4: unity at start, saturates at top
    for (int k = 0; k < 12; k++) frame(k, 1'b0, "R1 R4 unity");
    // R3/R5: full descent over every gain level
    for (int k = 0; k < 1023; k++) frame(k + 100, 1'b1, "R3 descent");
    check("R5 not muted after 1023", longint'(muted), 0);
    frame(2000, 1'b1, "R5 last step");
    check("R5 muted after 1024", longint'(muted), 1);
    // R6: hold at zero with corner samples
    for (int k = 0; k < 18; k++) frame(k, 1'b1, "R6 zero hold");
    // R4: full climb back
    for (int k = 0; k < 1030; k++) frame(k + 3000, 1'b0, "R4 climb");
    // R7: reversal mid ramp, both directions
    for (int k = 0; k < 300; k++) frame(k + 5000, 1'b1, "R7 down");
    for (int k = 0; k < 120; k++) frame(k + 6000, 1'b0, "R7 reverse up");
    for (int k = 0; k < 50; k++)  frame(k + 7000, 1'b1, "R7 reverse down");
    // R10: idle disturbance has no effect
    begin
      logic [23:0] hl, hr;
      hl = left_out; hr = right_out;
      for (int n = 0; n < 16; n++) begin
        mute_req = n[0]; left_in = sample(n + 40); right_in = sample(n + 41);
        @(negedge clk);
        check("R10 left hold",  longint'(left_out),  longint'(hl));
        check("R10 right hold", longint'(right_out), longint'(hr));
      end
    end
    frame(8, 1'b0, "R10 gain unchanged");
    frame(17, 1'b0, "R10 gain unchanged");
    // R8: identical samples give identical outputs
    for (int k = 0; k < 20; k++) begin
      left_in = sample(k); right_in = sample(k); mute_req = 1'b1; frame_vld = 1'b1;
      @(posedge clk); @(negedge clk);
      frame_vld = 1'b0;
      check("R8 channels match", longint'(right_out), longint'(left_out));
      check("R8 left value", longint'($signed(left_out)), exp_scale(sample(k), g_model));
      g_model = (g_model > 0) ? g_model - 1 : 0;
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule